// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Context-Free Auxiliary Requester

This block decides, once per cycle, which of several requesters may use a single shared memory port. The requesters are four DMA channels numbered 0 to 3, one auxiliary port fed by a peripheral, and the CPU. A channel takes part only when it is armed and its trigger is present. The auxiliary port keeps no transfer state of its own. Each request brings its own address, direction and write data, and the arbiter forwards them unchanged when that request wins.

One small control register sets the ranking. A 3-bit slot field places the auxiliary port at a chosen position among the fixed channel order. A single bit puts the CPU either above or below every DMA requester. The winner's access is registered onto the memory command outputs. The winner also receives a one-cycle grant. An auxiliary request that loses, or that arrives while the memory port is busy, receives a wait indication instead.

Top module: `dma_port_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every grant, `mem_valid` and `aux_wait` are 0 and `mem_src` is 7. Reset sets the slot field to 4 and `cfg_cpu_first` to 0.
- R2: Channel i can win only in a cycle where both `ch_arm[i]` and `ch_trig[i]` are 1.
- R3: Among eligible channels the lowest-numbered one wins. Channel 0 ranks highest.
- R4: The slot field s places the auxiliary port directly above channel s. Values 0 to 3 do this, 4 places it below channel 3, and values 5 to 7 behave as 4.
- R5: With `cfg_cpu_first`=1 a CPU request beats every DMA requester. With 0 it wins only when no channel is eligible and `aux_req` is 0.
- R6: The winner's address, write data and `we` appear on the memory outputs one cycle later, unchanged. `mem_src` then reads 0 to 3 for a channel, 4 for the auxiliary port and 5 for the CPU.
- R7: In a cycle where `mem_ready` is 0, nothing is granted and `mem_valid` is 0 one cycle later.
- R8: `aux_wait` is 1 one cycle after a cycle in which `aux_req` was 1 and the auxiliary port did not win. Otherwise it is 0.
- R9: The grants are registered one cycle after the requests are sampled. They are one-hot or all zero, and each lasts exactly one cycle.
- R10: A write with `cfg_we`=1 in cycle k changes the ranking from cycle k+1. Arbitration in cycle k still uses the old setting.
- R11: When `aux_req` is 0 the auxiliary port is never granted, even when it holds the top slot and nothing else requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_aux_slot | input | 3 | Auxiliary slot value to write |
| cfg_cpu_first | input | 1 | CPU-above-DMA bit to write |
| ch_arm | input | 4 | Channel armed flags |
| ch_trig | input | 4 | Channel trigger requests |
| ch_we | input | 4 | Channel write direction |
| ch_addr | input | 4*AW | Channel addresses, channel i at bits i*AW |
| ch_wdata | input | 4*DW | Channel write data, channel i at bits i*DW |
| aux_req | input | 1 | Auxiliary request |
| aux_we | input | 1 | Auxiliary direction, 1 = write |
| aux_addr | input | AW | Auxiliary address |
| aux_wdata | input | DW | Auxiliary write data |
| cpu_req | input | 1 | CPU request |
| cpu_we | input | 1 | CPU direction |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| mem_ready | input | 1 | Memory port can accept an access this cycle |
| mem_valid | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory access direction |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_src | output | 3 | Source of the access (0-3, 4, 5, 7 = none) |
| ch_gnt | output | 4 | Channel grants |
| aux_gnt | output | 1 | Auxiliary grant |
| aux_wait | output | 1 | Auxiliary request was held off |
| cpu_gnt | output | 1 | CPU grant |

## Verification
The properties assume that every input is a known 0 or 1 at each sampled edge. They also assume that request, address and data are sampled together in the same cycle, so a grant can always be traced to the values one edge earlier. The stimulus drives all inputs only on the falling clock edge and holds them at zero throughout reset. Random requests, memory readiness and control-register writes are drawn with a fixed seed, and every slot value from 0 to 7 is reached on purpose. This keeps the inputs within those assumptions while covering every ranking.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH    = 4;
  localparam int SRC_W  = 3;
  localparam int SLOT_W = 3;
  localparam logic [SRC_W-1:0]  SRC_AUX  = SRC_W'(NCH);
  localparam logic [SRC_W-1:0]  SRC_CPU  = SRC_W'(NCH + 1);
  localparam logic [SRC_W-1:0]  SRC_NONE = '1;
  localparam logic [SLOT_W-1:0] SLOT_LOW = SLOT_W'(NCH);
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot_in,
  input  logic              cpu_in,
  output logic [SLOT_W-1:0] slot_q,
  output logic              cpu_first_q
);
  // Out-of-range slot values are folded to the lowest slot at write time.
  logic [SLOT_W-1:0] slot_fold;
  assign slot_fold = (slot_in > SLOT_LOW) ? SLOT_LOW : slot_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q      <= SLOT_LOW;
      cpu_first_q <= 1'b0;
    end else if (we) begin
      slot_q      <= slot_fold;
      cpu_first_q <= cpu_in;
    end
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import dma_arb_pkg::*;
(
  input  logic [NCH-1:0]    ch_req,
  input  logic              aux_req,
  input  logic              cpu_req,
  input  logic              mem_ready,
  input  logic [SLOT_W-1:0] slot,
  input  logic              cpu_first,
  output logic [SRC_W-1:0]  win_src
);
  logic             dma_hit;
  logic [SRC_W-1:0] dma_src;

  // Walk the DMA ranking; at position k the auxiliary port sits above channel k.
  always_comb begin
    dma_hit = 1'b0;
    dma_src = SRC_NONE;
    for (int k = 0; k <= NCH; k++) begin
      if (!dma_hit && aux_req && (int'(slot) == k)) begin
        dma_hit = 1'b1;
        dma_src = SRC_AUX;
      end
      if (k < NCH) begin
        if (!dma_hit && ch_req[k]) begin
          dma_hit = 1'b1;
          dma_src = SRC_W'(k);
        end
      end
    end
  end

  always_comb begin
    if (!mem_ready)                win_src = SRC_NONE;
    else if (cpu_first && cpu_req) win_src = SRC_CPU;
    else if (dma_hit)              win_src = dma_src;
    else if (cpu_req)              win_src = SRC_CPU;
    else                           win_src = SRC_NONE;
  end
endmodule

// File: rtl/arb_issue.sv
module arb_issue
  import dma_arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  win_src,
  input  logic              aux_req,
  input  logic [NCH-1:0]    ch_we,
  input  logic [NCH*AW-1:0] ch_addr,
  input  logic [NCH*DW-1:0] ch_wdata,
  input  logic              aux_we,
  input  logic [AW-1:0]     aux_addr,
  input  logic [DW-1:0]     aux_wdata,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [SRC_W-1:0]  mem_src,
  output logic [NCH-1:0]    ch_gnt,
  output logic              aux_gnt,
  output logic              aux_wait,
  output logic              cpu_gnt
);
  logic          sel_we;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic [NCH-1:0] ch_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_hit
      assign ch_hit[gi] = (win_src == SRC_W'(gi));
    end
  endgenerate

  always_comb begin
    sel_we    = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    if (win_src == SRC_AUX) begin
      sel_we = aux_we; sel_addr = aux_addr; sel_wdata = aux_wdata;
    end else if (win_src == SRC_CPU) begin
      sel_we = cpu_we; sel_addr = cpu_addr; sel_wdata = cpu_wdata;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_hit[i]) begin
          sel_we    = ch_we[i];
          sel_addr  = ch_addr[i*AW +: AW];
          sel_wdata = ch_wdata[i*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_src   <= SRC_NONE;
      ch_gnt    <= '0;
      aux_gnt   <= 1'b0;
      aux_wait  <= 1'b0;
      cpu_gnt   <= 1'b0;
    end else begin
      mem_valid <= (win_src != SRC_NONE);
      mem_we    <= sel_we;
      mem_addr  <= sel_addr;
      mem_wdata <= sel_wdata;
      mem_src   <= win_src;
      ch_gnt    <= ch_hit;
      aux_gnt   <= (win_src == SRC_AUX);
      aux_wait  <= aux_req && (win_src != SRC_AUX);
      cpu_gnt   <= (win_src == SRC_CPU);
    end
  end
endmodule

// File: rtl/dma_port_arbiter.sv
module dma_port_arbiter
  import dma_arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_aux_slot,
  input  logic              cfg_cpu_first,
  input  logic [NCH-1:0]    ch_arm,
  input  logic [NCH-1:0]    ch_trig,
  input  logic [NCH-1:0]    ch_we,
  input  logic [NCH*AW-1:0] ch_addr,
  input  logic [NCH*DW-1:0] ch_wdata,
  input  logic              aux_req,
  input  logic              aux_we,
  input  logic [AW-1:0]     aux_addr,
  input  logic [DW-1:0]     aux_wdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [SRC_W-1:0]  mem_src,
  output logic [NCH-1:0]    ch_gnt,
  output logic              aux_gnt,
  output logic              aux_wait,
  output logic              cpu_gnt
);
  logic [SLOT_W-1:0] cfg_slot_q;
  logic              cfg_cpu_q;
  logic [SRC_W-1:0]  win_src;
  logic [NCH-1:0]    ch_req;

  assign ch_req = ch_arm & ch_trig;

  arb_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .slot_in(cfg_aux_slot),
    .cpu_in(cfg_cpu_first), .slot_q(cfg_slot_q), .cpu_first_q(cfg_cpu_q)
  );

  arb_pick u_pick (
    .ch_req(ch_req), .aux_req(aux_req), .cpu_req(cpu_req),
    .mem_ready(mem_ready), .slot(cfg_slot_q), .cpu_first(cfg_cpu_q),
    .win_src(win_src)
  );

  arb_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk(clk), .rst(rst), .win_src(win_src), .aux_req(aux_req),
    .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
    .aux_we(aux_we), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_src(mem_src), .ch_gnt(ch_gnt),
    .aux_gnt(aux_gnt), .aux_wait(aux_wait), .cpu_gnt(cpu_gnt)
  );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker
  import dma_arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    ch_arm,
  input logic [NCH-1:0]    ch_trig,
  input logic              aux_req,
  input logic              aux_we,
  input logic [AW-1:0]     aux_addr,
  input logic              cpu_req,
  input logic              cfg_cpu_q,
  input logic              mem_ready,
  input logic              mem_valid,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [NCH-1:0]    ch_gnt,
  input logic              aux_gnt,
  input logic              aux_wait,
  input logic              cpu_gnt
);
  // R9: at most one grant at a time
  a_r9_onehot_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_gnt, aux_gnt, ch_gnt}));

  // R7: a busy memory port issues nothing
  a_r7_busy_no_issue: assert property (@(posedge clk) disable iff (rst)
    !$past(mem_ready) |-> !mem_valid);

  // R8: wait only follows a pending, ungranted auxiliary request
  a_r8_wait_cause: assert property (@(posedge clk) disable iff (rst)
    aux_wait |-> ($past(aux_req) && !aux_gnt));

  // R11: no auxiliary grant without a request
  a_r11_aux_needs_req: assert property (@(posedge clk) disable iff (rst)
    aux_gnt |-> $past(aux_req));

  // R6: auxiliary address and direction forwarded unchanged
  a_r6_aux_forward: assert property (@(posedge clk) disable iff (rst)
    aux_gnt |-> (mem_addr == $past(aux_addr) && mem_we == $past(aux_we)));

  // R5: a low-ranked CPU wins only with no DMA demand
  a_r5_cpu_low: assert property (@(posedge clk) disable iff (rst)
    (cpu_gnt && !$past(cfg_cpu_q)) |-> ($past((ch_arm & ch_trig) == '0) && !$past(aux_req)));

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      // R2: a channel grant needs arm and trigger together
      a_r2_ch_eligible: assert property (@(posedge clk) disable iff (rst)
        ch_gnt[gi] |-> $past(ch_arm[gi] && ch_trig[gi]));
    end
  endgenerate
endmodule

bind dma_port_arbiter dma_arb_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ch_arm(ch_arm), .ch_trig(ch_trig),
  .aux_req(aux_req), .aux_we(aux_we), .aux_addr(aux_addr), .cpu_req(cpu_req),
  .cfg_cpu_q(cfg_cpu_q), .mem_ready(mem_ready), .mem_valid(mem_valid),
  .mem_we(mem_we), .mem_addr(mem_addr), .ch_gnt(ch_gnt), .aux_gnt(aux_gnt),
  .aux_wait(aux_wait), .cpu_gnt(cpu_gnt)
);

// File: tb/sim_dma_port_arbiter.sv
`timescale 1ns/1ps
module sim_dma_port_arbiter;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int N  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          cfg_we = 0, cfg_cpu_first = 0;
  logic [2:0]    cfg_aux_slot = 0;
  logic [N-1:0]  ch_arm = 0, ch_trig = 0, ch_we = 0;
  logic [N*AW-1:0] ch_addr = 0;
  logic [N*DW-1:0] ch_wdata = 0;
  logic          aux_req = 0, aux_we = 0, cpu_req = 0, cpu_we = 0, mem_ready = 0;
  logic [AW-1:0] aux_addr = 0, cpu_addr = 0;
  logic [DW-1:0] aux_wdata = 0, cpu_wdata = 0;
  logic          mem_valid, mem_we, aux_gnt, aux_wait, cpu_gnt;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [2:0]    mem_src;
  logic [N-1:0]  ch_gnt;

  dma_port_arbiter #(.AW(AW), .DW(DW)) u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench model of the control register and the expected outputs
  logic [2:0] m_slot = 3'd4;
  logic       m_cpu  = 1'b0;
  logic [2:0] e_src = 3'd7;
  logic       e_wait = 0, e_we = 0;
  logic [AW-1:0] e_addr = 0;
  logic [DW-1:0] e_wdata = 0;
  string      e_tag = "R1";

  function automatic logic [2:0] model_pick(input logic [N-1:0] chq, input logic aq,
      input logic cq, input logic rdy, input logic [2:0] slot, input logic cf);
    int ord[N+2];
    int n = 0;
    int s = (slot > 3'd4) ? 4 : int'(slot);
    if (cf) begin ord[n] = 5; n++; end
    for (int p = 0; p <= N; p++) begin
      if (p == s) begin ord[n] = 4; n++; end
      if (p < N)  begin ord[n] = p; n++; end
    end
    if (!cf) begin ord[n] = 5; n++; end
    if (!rdy) return 3'd7;
    for (int i = 0; i < N + 2; i++) begin
      if (ord[i] < N && chq[ord[i]]) return 3'(ord[i]);
      if (ord[i] == 4 && aq) return 3'd4;
      if (ord[i] == 5 && cq) return 3'd5;
    end
    return 3'd7;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: check the previous prediction, then apply the staged inputs.
  task automatic cycle();
    logic [N-1:0] gexp;
    @(negedge clk);
    check({e_tag, " src/R9"}, {61'd0, mem_src}, {61'd0, e_src});
    check("R6 valid", {63'd0, mem_valid}, {63'd0, e_src != 3'd7});
    for (int i = 0; i < N; i++) gexp[i] = (e_src == 3'(i));
    check("R9 grants", {57'd0, cpu_gnt, aux_gnt, ch_gnt},
          {57'd0, e_src == 3'd5, e_src == 3'd4, gexp});
    check("R8 aux_wait", {63'd0, aux_wait}, {63'd0, e_wait});
    if (e_src != 3'd7)
      check("R6 data", {mem_we, mem_addr[30:0], mem_wdata}, {e_we, e_addr[30:0], e_wdata});
  endtask

  task automatic stage_and_predict(input string tag);
    e_tag  = tag;
    e_src  = model_pick(ch_arm & ch_trig, aux_req, cpu_req, mem_ready, m_slot, m_cpu);
    e_wait = aux_req && (e_src != 3'd4);
    e_we = 0; e_addr = 0; e_wdata = 0;
    if (e_src < 3'd4) begin
      e_we = ch_we[e_src]; e_addr = ch_addr[e_src*AW +: AW]; e_wdata = ch_wdata[e_src*DW +: DW];
    end else if (e_src == 3'd4) begin
      e_we = aux_we; e_addr = aux_addr; e_wdata = aux_wdata;
    end else if (e_src == 3'd5) begin
      e_we = cpu_we; e_addr = cpu_addr; e_wdata = cpu_wdata;
    end
    if (cfg_we) begin
      m_slot = cfg_aux_slot;
      m_cpu  = cfg_cpu_first;
    end
  endtask

  task automatic randomize_inputs();
    ch_arm = 4'($urandom); ch_trig = 4'($urandom); ch_we = 4'($urandom);
    for (int i = 0; i < N; i++) begin
      ch_addr[i*AW +: AW]  = $urandom;
      ch_wdata[i*DW +: DW] = $urandom;
    end
    aux_req = ($urandom % 3) == 0; aux_we = 1'($urandom);
    aux_addr = $urandom; aux_wdata = $urandom;
    cpu_req = ($urandom % 3) == 0; cpu_we = 1'($urandom);
    cpu_addr = $urandom; cpu_wdata = $urandom;
    mem_ready = ($urandom % 5) != 0;
    cfg_we = ($urandom % 16) == 0;
    cfg_aux_slot = 3'($urandom); cfg_cpu_first = 1'($urandom);
  endtask

  task automatic idle_inputs();
    ch_arm = 0; ch_trig = 0; aux_req = 0; cpu_req = 0; cfg_we = 0; mem_ready = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 reset valid", {63'd0, mem_valid}, 64'd0);
    check("R1 reset src", {61'd0, mem_src}, 64'd7);
    check("R1 reset grants", {57'd0, cpu_gnt, aux_gnt, ch_gnt, aux_wait}, 64'd0);
    rst = 1'b0;
    idle_inputs();
    // R11: aux port holds top slot from reset? no: reset slot 4; nothing requests
    stage_and_predict("R11");
    cycle();
    // R1: reset ranking is slot 4 with CPU below: ch3 beats aux, aux beats CPU
    ch_arm = 4'b1000; ch_trig = 4'b1000; aux_req = 1; cpu_req = 1;
    ch_addr[3*AW +: AW] = 32'h3333_0000;
    stage_and_predict("R1 default order");
    cycle();
    ch_arm = 0; aux_addr = 32'hA0A0_0004; aux_we = 1; aux_wdata = 32'hDEAD_BEEF;
    stage_and_predict("R1 aux over cpu");
    cycle();
    // R2: armed without trigger, trigger without arm
    idle_inputs(); ch_arm = 4'b0101; ch_trig = 4'b1010;
    stage_and_predict("R2");
    cycle();
    // R4 and R10: sweep every slot value with all requesters active
    for (int s = 0; s < 8; s++) begin
      idle_inputs(); cfg_we = 1; cfg_aux_slot = 3'(s); cfg_cpu_first = 0;
      ch_arm = 4'b1111; ch_trig = 4'b1111; aux_req = 1; cpu_req = 1;
      stage_and_predict("R10 old setting");
      cycle();
      cfg_we = 0;
      for (int m = 0; m < 16; m++) begin
        ch_trig = 4'(m);
        stage_and_predict("R4 R3 slot");
        cycle();
      end
    end
    // R5: CPU ranked first beats everyone
    idle_inputs(); cfg_we = 1; cfg_aux_slot = 0; cfg_cpu_first = 1;
    stage_and_predict("R10");
    cycle();
    cfg_we = 0; ch_arm = 4'b1111; ch_trig = 4'b0001; aux_req = 1; cpu_req = 1;
    stage_and_predict("R5 cpu first");
    cycle();
    // R7: busy memory port
    mem_ready = 0;
    stage_and_predict("R7 busy");
    cycle();
    // R11: aux at top slot, no request, nothing else
    idle_inputs();
    stage_and_predict("R11 aux idle");
    cycle();
    // Random phase
    for (int t = 0; t < 3000; t++) begin
      randomize_inputs();
      stage_and_predict("R3 R4 R5 R8 random");
      cycle();
    end
    idle_inputs();
    stage_and_predict("R9 drain");
    cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule